// File: doc/BRIEF.md
# Serial Receive Status Flag Controller

This block sits between the bit-level receive engine of an asynchronous serial port and the CPU. Each time the engine signals a completed frame, the block decides whether the frame is delivered to the data holding register or dropped. It then updates five status flags: data ready, overrun, noise, framing error and parity error. Parity checking can be turned on or off, and the parity type can be even or odd.

The flags are sticky. Software clears a flag with two reads. First it reads the status register while that flag is set, which arms the flag. Then it reads the data register, which clears every armed flag. A data read with no earlier status read clears nothing. Overrun can therefore outlive the ready flag, and in that case one more status read and data read are needed to clear it. While a framing error is pending, no new frame is delivered to the data register.

Top module: `uart_rx_flag_ctrl`

## Requirements
- R1: After reset every flag is 0 and a status read returns 0x00. The status layout is ready at bit 5, overrun at bit 3, noise at bit 2, framing error at bit 1 and parity error at bit 0. Bits 7, 6 and 4 always read 0.
- R2: A frame that completes while ready and framing error are both clear is loaded into the data register, and ready reads 1 from the next cycle.
- R3: A flag clears only on a data read that follows a status read which returned that flag as 1. A data read with no such status read leaves every flag unchanged, still returns the held byte, and ends all arming.
- R4: A frame that completes while ready is 1 sets overrun. That frame is discarded, and the data register keeps its earlier byte.
- R5: Suppose a status read happened before an overrun and a data read follows. That data read clears ready but leaves overrun set. A later status read returns 0x08, and one further data read clears overrun.
- R6: A frame completion and a data read in the same cycle, with ready armed, set overrun and clear ready. That data read does not clear the overrun.
- R7: Noise sets together with ready when the accepted frame carries the noise indication.
- R8: Framing error sets together with ready when the sampled stop bit is 0. While framing error is set, no frame is loaded into the data register.
- R9: Parity error sets only when parity checking is enabled and the count of ones over the data byte and the received parity bit is odd for even type, or even for odd type.
- R10: A discarded overrun frame sets none of noise, framing error or parity error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_valid_i | input | 1 | One-cycle frame-complete pulse from the receive engine |
| frame_data_i | input | DATA_W | Received data byte |
| frame_noise_i | input | 1 | Noise seen while sampling the frame |
| frame_stop_i | input | 1 | Sampled stop bit value |
| frame_par_i | input | 1 | Received parity bit |
| par_en_i | input | 1 | Parity checking enabled |
| par_odd_i | input | 1 | 1 selects odd parity, 0 selects even parity |
| stat_rd_i | input | 1 | Status register read strobe |
| data_rd_i | input | 1 | Data register read strobe |
| stat_o | output | 8 | Status register value |
| data_o | output | DATA_W | Data register value |

## Verification
The assertions assume that frame-complete pulses last one cycle and that the read strobes are single-cycle pulses. They also assume that a status read and a data read never occur in the same cycle. The scoreboard driver follows these rules: it raises each strobe for exactly one cycle, issues status and data reads in separate cycles, and pairs a frame with a data read only in the deliberate same-cycle overrun case. Parity settings change only between frames, so a frame's parity result never depends on a configuration that changes partway through the frame.

// File: rtl/uart_rx_flag_pkg.sv
package uart_rx_flag_pkg;
  localparam int unsigned NUM_FLAGS = 5;
  localparam int unsigned STAT_W    = 8;

  // internal flag vector order
  localparam int unsigned IDX_PE  = 0;
  localparam int unsigned IDX_FE  = 1;
  localparam int unsigned IDX_NF  = 2;
  localparam int unsigned IDX_OR  = 3;
  localparam int unsigned IDX_RDY = 4;

  // status register positions (decoded by software)
  localparam int unsigned BIT_PE  = 0;
  localparam int unsigned BIT_FE  = 1;
  localparam int unsigned BIT_NF  = 2;
  localparam int unsigned BIT_OR  = 3;
  localparam int unsigned BIT_RDY = 5;

  function automatic logic [STAT_W-1:0] pack_status(input logic [NUM_FLAGS-1:0] f);
    logic [STAT_W-1:0] s;
    s          = '0;
    s[BIT_PE]  = f[IDX_PE];
    s[BIT_FE]  = f[IDX_FE];
    s[BIT_NF]  = f[IDX_NF];
    s[BIT_OR]  = f[IDX_OR];
    s[BIT_RDY] = f[IDX_RDY];
    return s;
  endfunction
endpackage

// File: rtl/rx_frame_eval.sv
module rx_frame_eval #(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic              par_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              stop_i,
  input  logic              noise_i,
  output logic              pe_o,
  output logic              fe_o,
  output logic              nf_o
);
  logic ones_odd;

  always_comb begin
    ones_odd = (^data_i) ^ par_i;
    // even type wants an even total, odd type an odd total
    pe_o     = par_en_i && (ones_odd != par_odd_i);
    fe_o     = !stop_i;
    nf_o     = noise_i;
  end
endmodule

// File: rtl/rx_data_hold.sv
module rx_data_hold #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ready_i,
  input  logic              fe_pend_i,
  output logic              accept_o,
  output logic              overrun_o,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] data_q;

  always_comb begin
    overrun_o = valid_i && ready_i;
    accept_o  = valid_i && !ready_i && !fe_pend_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       data_q <= '0;
    else if (accept_o) data_q <= data_i;
  end

  assign data_o = data_q;
endmodule

// File: rtl/rx_flag_cell.sv
module rx_flag_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic stat_rd_i,
  input  logic data_rd_i,
  output logic flag_o
);
  logic flag_q, arm_q;
  logic flag_d, arm_d;

  always_comb begin
    // a set in the same cycle wins over a clear
    flag_d = flag_q;
    if (data_rd_i && arm_q) flag_d = 1'b0;
    if (set_i)              flag_d = 1'b1;

    arm_d = data_rd_i ? 1'b0 : arm_q;
    if (stat_rd_i && flag_q) arm_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      arm_q  <= arm_d;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/uart_rx_flag_ctrl.sv
module uart_rx_flag_ctrl
  import uart_rx_flag_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_valid_i,
  input  logic [DATA_W-1:0] frame_data_i,
  input  logic              frame_noise_i,
  input  logic              frame_stop_i,
  input  logic              frame_par_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              stat_rd_i,
  input  logic              data_rd_i,
  output logic [7:0]        stat_o,
  output logic [DATA_W-1:0] data_o
);
  logic [NUM_FLAGS-1:0] flags;
  logic [NUM_FLAGS-1:0] set_vec;
  logic accept, overrun;
  logic pe_chk, fe_chk, nf_chk;

  rx_frame_eval #(.DATA_W(DATA_W)) i_eval (
    .data_i    (frame_data_i),
    .par_i     (frame_par_i),
    .par_en_i  (par_en_i),
    .par_odd_i (par_odd_i),
    .stop_i    (frame_stop_i),
    .noise_i   (frame_noise_i),
    .pe_o      (pe_chk),
    .fe_o      (fe_chk),
    .nf_o      (nf_chk)
  );

  rx_data_hold #(.DATA_W(DATA_W)) i_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (frame_valid_i),
    .data_i    (frame_data_i),
    .ready_i   (flags[IDX_RDY]),
    .fe_pend_i (flags[IDX_FE]),
    .accept_o  (accept),
    .overrun_o (overrun),
    .data_o    (data_o)
  );

  // error flags only follow an accepted frame
  always_comb begin
    set_vec          = '0;
    set_vec[IDX_RDY] = accept;
    set_vec[IDX_OR]  = overrun;
    set_vec[IDX_NF]  = accept && nf_chk;
    set_vec[IDX_FE]  = accept && fe_chk;
    set_vec[IDX_PE]  = accept && pe_chk;
  end

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    rx_flag_cell i_cell (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .set_i     (set_vec[g]),
      .stat_rd_i (stat_rd_i),
      .data_rd_i (data_rd_i),
      .flag_o    (flags[g])
    );
  end

  assign stat_o = pack_status(flags);
endmodule

// File: rtl/uart_rx_flag_chk.sv
module uart_rx_flag_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              frame_valid_i,
  input logic              data_rd_i,
  input logic [7:0]        stat_o,
  input logic [DATA_W-1:0] data_o
);
  assert_reserved_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o[7:6] == 2'b00) && !stat_o[4]);

  assert_accept_sets_ready_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_valid_i && !stat_o[5] && !stat_o[1]) |=> stat_o[5]);

  assert_ready_clear_by_read_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(stat_o[5]) |-> $past(data_rd_i));

  assert_overrun_clear_by_read_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(stat_o[3]) |-> $past(data_rd_i));

  assert_overrun_keeps_data_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_valid_i && stat_o[5]) |=> (stat_o[3] && $stable(data_o)));

  assert_noise_with_ready_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_o[2]) |-> $rose(stat_o[5]));

  assert_fe_with_ready_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_o[1]) |-> $rose(stat_o[5]));

  assert_pe_with_ready_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_o[0]) |-> $rose(stat_o[5]));
endmodule

bind uart_rx_flag_ctrl uart_rx_flag_chk #(.DATA_W(DATA_W)) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .frame_valid_i (frame_valid_i),
  .data_rd_i     (data_rd_i),
  .stat_o        (stat_o),
  .data_o        (data_o)
);

// File: tb/test_uart_rx_flag_ctrl.sv
module test_uart_rx_flag_ctrl;
  localparam int unsigned DATA_W = 8;

  typedef struct {
    bit          is_stat;
    logic [7:0]  val;
    string       req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_valid = 1'b0;
  logic [DATA_W-1:0] frame_data = '0;
  logic frame_noise = 1'b0, frame_stop = 1'b1, frame_par = 1'b0;
  logic par_en = 1'b0, par_odd = 1'b0;
  logic stat_rd = 1'b0, data_rd = 1'b0;
  logic [7:0] stat;
  logic [DATA_W-1:0] data;

  exp_t q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  uart_rx_flag_ctrl #(.DATA_W(DATA_W)) i_uart_rx_flag_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .frame_valid_i(frame_valid), .frame_data_i(frame_data),
    .frame_noise_i(frame_noise), .frame_stop_i(frame_stop), .frame_par_i(frame_par),
    .par_en_i(par_en), .par_odd_i(par_odd), .stat_rd_i(stat_rd), .data_rd_i(data_rd),
    .stat_o(stat), .data_o(data));

  // monitor: compare read results mid-cycle
  always @(negedge clk) begin
    if (rst_n && (stat_rd || data_rd)) begin
      if (q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL scoreboard: unexpected read, actual stat=%h data=%h expected none", stat, data);
      end else begin
        exp_t e;
        logic [7:0] act;
        e = q.pop_front();
        act = e.is_stat ? stat : data;
        n_chk++;
        if (act !== e.val) begin
          n_fail++;
          $display("FAIL %s: %s read actual=%h expected=%h", e.req,
                   e.is_stat ? "status" : "data", act, e.val);
        end
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
    frame_valid = 1'b0; stat_rd = 1'b0; data_rd = 1'b0;
  endtask

  task automatic frame(input logic [7:0] d, input logic nz, input logic st, input logic p);
    @(posedge clk); #1;
    frame_valid = 1'b1; frame_data = d; frame_noise = nz; frame_stop = st; frame_par = p;
    tick();
  endtask

  task automatic rd_stat(input logic [7:0] exp_v, input string req);
    q.push_back('{1'b1, exp_v, req});
    @(posedge clk); #1; stat_rd = 1'b1;
    tick();
  endtask

  task automatic rd_data(input logic [7:0] exp_v, input string req);
    q.push_back('{1'b0, exp_v, req});
    @(posedge clk); #1; data_rd = 1'b1;
    tick();
  endtask

  task automatic frame_and_rd(input logic [7:0] d, input logic [7:0] exp_v, input string req);
    q.push_back('{1'b0, exp_v, req});
    @(posedge clk); #1;
    frame_valid = 1'b1; frame_data = d; frame_noise = 1'b0; frame_stop = 1'b1; data_rd = 1'b1;
    tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset value
    rd_stat(8'h00, "R1");
    // R2 clean frame, R3 normal clear
    frame(8'hA5, 0, 1, 0);
    rd_stat(8'h20, "R2");
    rd_data(8'hA5, "R2");
    rd_stat(8'h00, "R3");
    // R3 data read without status read clears nothing
    frame(8'h3C, 0, 1, 0);
    rd_data(8'h3C, "R3");
    rd_stat(8'h20, "R3");
    rd_data(8'h3C, "R3");
    rd_stat(8'h00, "R3");
    // R4 overrun discards second frame
    frame(8'h11, 0, 1, 0);
    frame(8'h22, 0, 1, 0);
    rd_stat(8'h28, "R4");
    rd_data(8'h11, "R4");
    rd_stat(8'h00, "R4");
    // R5 status read before overrun
    frame(8'h44, 0, 1, 0);
    rd_stat(8'h20, "R5");
    frame(8'h55, 0, 1, 0);
    rd_data(8'h44, "R5");
    rd_stat(8'h08, "R5");
    rd_data(8'h44, "R5");
    rd_stat(8'h00, "R5");
    // R6 overrun and data read in the same cycle
    frame(8'h66, 0, 1, 0);
    rd_stat(8'h20, "R6");
    frame_and_rd(8'h77, 8'h66, "R6");
    rd_stat(8'h08, "R6");
    rd_data(8'h66, "R6");
    rd_stat(8'h00, "R6");
    // R7 noise
    frame(8'h12, 1, 1, 0);
    rd_stat(8'h24, "R7");
    rd_data(8'h12, "R7");
    rd_stat(8'h00, "R7");
    // R8 framing error blocks transfer
    frame(8'h34, 0, 0, 0);
    rd_stat(8'h22, "R8");
    frame(8'h56, 0, 1, 0);
    rd_stat(8'h2A, "R8");
    rd_data(8'h34, "R8");
    rd_stat(8'h00, "R8");
    frame(8'h78, 0, 1, 0);
    rd_stat(8'h20, "R8");
    rd_data(8'h78, "R8");
    // R9 parity
    par_en = 1'b1; par_odd = 1'b0;
    frame(8'h01, 0, 1, 0);
    rd_stat(8'h21, "R9");
    rd_data(8'h01, "R9");
    frame(8'h01, 0, 1, 1);
    rd_stat(8'h20, "R9");
    rd_data(8'h01, "R9");
    par_odd = 1'b1;
    frame(8'h03, 0, 1, 0);
    rd_stat(8'h21, "R9");
    rd_data(8'h03, "R9");
    frame(8'h01, 0, 1, 0);
    rd_stat(8'h20, "R9");
    rd_data(8'h01, "R9");
    par_en = 1'b0;
    frame(8'h03, 0, 1, 0);
    rd_stat(8'h20, "R9");
    rd_data(8'h03, "R9");
    // R10 overrun frame sets no error flags
    par_en = 1'b1; par_odd = 1'b0;
    frame(8'h10, 0, 1, 1);
    frame(8'h20, 1, 0, 0);
    rd_stat(8'h28, "R10");
    rd_data(8'h10, "R10");
    rd_stat(8'h00, "R10");
    par_en = 1'b0;
    repeat (2) tick();
    if (q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL scoreboard: actual=%0d pending expected=0", q.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule